// File: doc/BRIEF.md
# Dual-Channel Indirect Register Access Port

This block is the bus-side register front end of a two-channel serial communications controller. Each channel is reached through two byte addresses: a control address and a data address. A control write made while a channel's pointer is zero loads a register index into that pointer and can carry a command code. The next control access to that channel then reaches the selected register, and the pointer falls back to zero. One command code adds a high-bank bit to the index, so the same three index bits can also reach registers 8 to 15.

For each channel the port keeps sixteen byte-wide write registers and sixteen read registers. All write registers are driven out flat for the serial engine. Writing index 9 is not a store. Instead it decodes a software reset of channel B, channel A or both. The port also works out the bit-clock divisor for each channel. This is the 16-bit divisor held in registers 13:12, plus two, times the clock multiplier chosen by write register 4 bits 7:6. Data-address accesses do not touch the pointer. They only pulse strobes, so the transmit and receive paths outside the block can move bytes.

Each channel's pointer is a small state machine with two states. `PTR_BASE` means the pointer is zero. `PTR_SELECTED` means a register has been chosen. It has these transitions:
- BASE to SELECTED on a control write that loads a nonzero index.
- SELECTED to BASE on any control read.
- SELECTED to BASE on any control write, except one: a reset command written at index 9 that leaves this channel out of the reset. That write keeps the channel in SELECTED with the index still at 9.
- Any state to BASE when this channel is reset.

Top module: `sccx_regport`

## Requirements
- R1: Address bit ADDR_SHIFT selects data (1) or control (0). Address bit ADDR_SHIFT+1 selects the channel, where 0 is channel B and 1 is channel A.
- R2: A control write at pointer 0 loads the pointer with {bits 5:3 == 3'b001, bits 2:0}. It stores nothing. Any command code in bits 5:3 from 2 to 7 pulses that channel's `cmd_stb` for one cycle, with the code on `cmd_code`. Codes 0 and 1 do not pulse it.
- R3: A control read at pointer p returns read register p on `bus_rdata` in the next cycle. Any control read returns the pointer to 0. So does any control write at a nonzero pointer, except for the case given in R6.
- R4: A control write at pointer p (p from 1 to 15, but not 9) stores the byte in write register p, which shows on the channel's flat output in the next cycle. Byte p sits at bits 8p+7:8p.
- R5: Writes to registers 12 and 13 are also copied into read registers 12 and 13. Read registers 2 to 11, 14 and 15 always read 0.
- R6: A control write at pointer 9 is never stored. In that write, bit 6 resets channel B and bit 7 resets channel A. If the write resets neither channel, it has no effect and the pointer returns to 0. A channel that is reset has its pointer set to 0. The writing channel keeps its pointer at 9 when its own reset bit is clear and the other channel's bit is set.
- R7: After reset, whether from the reset input or from a software reset:
  - write registers: 4 = 0x04, 9 = 0xC0, 11 = 0x08, 14 = 0x30, 15 = 0xF8, all others 0;
  - read register 1 = 0x07;
  - read register 0 = 0x44, or 0x7C when `strap_disabled` is high at reset.
- R8: The rate divisor is ({reg13, reg12} + 2) × M, where M = 1, 16, 32 or 64 for reg4 bits 7:6 = 0, 1, 2 or 3.
- R9: A data write pulses `data_wr_stb` for the channel and puts the byte on `tx_byte`. A data read pulses `data_rd_stb` and returns that channel's receive byte on `bus_rdata`. Neither one changes the pointer.
- R10: When `bus_wr` and `bus_rd` are both high, only the write takes effect. `bus_rdata` changes only after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_disabled | input | 1 | Chooses the reset value of read register 0 |
| bus_addr | input | ADDR_SHIFT+2 | Byte address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after the read |
| rx_byte_b | input | 8 | Receive byte of channel B |
| rx_byte_a | input | 8 | Receive byte of channel A |
| wreg_b | output | 128 | Write registers of channel B, flat |
| wreg_a | output | 128 | Write registers of channel A, flat |
| rate_div_b | output | 23 | Rate divisor of channel B |
| rate_div_a | output | 23 | Rate divisor of channel A |
| cmd_stb | output | 2 | Command pulse per channel (bit 0 = B) |
| cmd_code | output | 3 | Code of the last command |
| data_wr_stb | output | 2 | Data write pulse per channel |
| data_rd_stb | output | 2 | Data read pulse per channel |
| tx_byte | output | 8 | Last data byte written |

## Verification
The hardest state to reach is a channel left holding pointer 9 after it has reset only the other channel. Its pointer cannot be seen at the ports. The stimulus writes a single-channel reset and then issues a control read on the writing channel. That read returns read register 9 (0x00) instead of read register 0 (0x44). A follow-up write of 0xC0 through the same held pointer then resets both channels. Every write register is swept on both channels, through both the low and the high bank. The rate divisor is swept over all four multipliers and the extreme divisor values.

// File: rtl/sccx_pkg.sv
package sccx_pkg;
    localparam int REG_W   = 8;
    localparam int NREG    = 16;
    localparam int IDX_W   = $clog2(NREG);
    localparam int NCHAN   = 2;
    localparam int DIV_W   = 2 * REG_W + 1;
    localparam int RATE_W  = DIV_W + 6;

    localparam logic [2:0]       CMD_POINT_HIGH = 3'd1;
    localparam logic [IDX_W-1:0] IDX_MODE       = 4'd4;
    localparam logic [IDX_W-1:0] IDX_RESET_CMD  = 4'd9;
    localparam logic [IDX_W-1:0] IDX_DIV_LO     = 4'd12;
    localparam logic [IDX_W-1:0] IDX_DIV_HI     = 4'd13;

    typedef enum logic [0:0] {
        PTR_BASE     = 1'b0,
        PTR_SELECTED = 1'b1
    } ptr_state_e;

    function automatic logic [REG_W-1:0] wreg_reset_val(input int idx);
        case (idx)
            4:       return 8'h04;
            9:       return 8'hC0;
            11:      return 8'h08;
            14:      return 8'h30;
            15:      return 8'hF8;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] rreg_reset_val(input int idx, input logic strap);
        case (idx)
            0:       return strap ? 8'h7C : 8'h44;
            1:       return 8'h07;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/sccx_addr_decode.sv
module sccx_addr_decode #(
    parameter int ADDR_SHIFT = 0
) (
    input  logic [ADDR_SHIFT+1:0] addr,
    output logic                  chan_sel,
    output logic                  is_data
);
    assign is_data  = addr[ADDR_SHIFT];
    assign chan_sel = addr[ADDR_SHIFT+1];
endmodule

// File: rtl/sccx_ptr_fsm.sv
module sccx_ptr_fsm
    import sccx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_rd,
    input  logic [REG_W-1:0] wbyte,
    input  logic             reset_me,
    output logic [IDX_W-1:0] ptr
);
    ptr_state_e       state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [IDX_W-1:0] load_idx;
    logic             is_reset_cmd;

    assign load_idx     = {wbyte[5:3] == CMD_POINT_HIGH, wbyte[2:0]};
    assign is_reset_cmd = (ptr_q == IDX_RESET_CMD) && (wbyte[7:6] != 2'b00);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PTR_BASE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (reset_me) begin
            state_d = PTR_BASE;
            ptr_d   = '0;
        end else begin
            unique case (state_q)
                PTR_BASE: begin
                    if (ctl_wr) begin
                        ptr_d   = load_idx;
                        state_d = (load_idx != '0) ? PTR_SELECTED : PTR_BASE;
                    end
                end
                PTR_SELECTED: begin
                    if (ctl_wr) begin
                        if (!is_reset_cmd) begin
                            state_d = PTR_BASE;
                            ptr_d   = '0;
                        end
                    end else if (ctl_rd) begin
                        state_d = PTR_BASE;
                        ptr_d   = '0;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ptr = ptr_q;
    end
endmodule

// File: rtl/sccx_chan_regs.sv
module sccx_chan_regs
    import sccx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strap_disabled,
    input  logic                  soft_rst,
    input  logic                  store_en,
    input  logic [IDX_W-1:0]      store_idx,
    input  logic [REG_W-1:0]      store_byte,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [REG_W-1:0]      rd_byte,
    output logic [NREG*REG_W-1:0] wreg_flat,
    output logic [RATE_W-1:0]     rate_div
);
    logic [REG_W-1:0] wreg_q [NREG];
    logic [REG_W-1:0] rreg_q [NREG];
    logic             clr;

    assign clr = !rst_n || soft_rst;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (clr)
                wreg_q[i] <= wreg_reset_val(i);
            else if (store_en && store_idx == IDX_W'(i))
                wreg_q[i] <= store_byte;
        end
        assign wreg_flat[i*REG_W +: REG_W] = wreg_q[i];

        if (i == int'(IDX_DIV_LO) || i == int'(IDX_DIV_HI)) begin : g_mirror
            always_ff @(posedge clk) begin
                if (clr)
                    rreg_q[i] <= '0;
                else if (store_en && store_idx == IDX_W'(i))
                    rreg_q[i] <= store_byte;
            end
        end else if (i < 2) begin : g_status
            always_ff @(posedge clk) begin
                if (clr)
                    rreg_q[i] <= rreg_reset_val(i, strap_disabled);
            end
        end else begin : g_zero
            assign rreg_q[i] = '0;
        end
    end

    assign rd_byte = rreg_q[rd_idx];

    logic [DIV_W-1:0]  div_base;
    logic [RATE_W-1:0] div_wide;
    logic [1:0]        mult_sel;

    assign div_base = {1'b0, wreg_q[IDX_DIV_HI], wreg_q[IDX_DIV_LO]} + DIV_W'(2);
    assign div_wide = RATE_W'(div_base);
    assign mult_sel = wreg_q[IDX_MODE][7:6];

    always_comb begin
        unique case (mult_sel)
            2'd0: rate_div = div_wide;
            2'd1: rate_div = div_wide << 4;
            2'd2: rate_div = div_wide << 5;
            2'd3: rate_div = div_wide << 6;
        endcase
    end
endmodule

// File: rtl/sccx_regport.sv
module sccx_regport
    import sccx_pkg::*;
#(
    parameter int ADDR_SHIFT = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strap_disabled,
    input  logic [ADDR_SHIFT+1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [7:0]            rx_byte_b,
    input  logic [7:0]            rx_byte_a,
    output logic [127:0]          wreg_b,
    output logic [127:0]          wreg_a,
    output logic [22:0]           rate_div_b,
    output logic [22:0]           rate_div_a,
    output logic [1:0]            cmd_stb,
    output logic [2:0]            cmd_code,
    output logic [1:0]            data_wr_stb,
    output logic [1:0]            data_rd_stb,
    output logic [7:0]            tx_byte
);
    logic             chan_sel, is_data;
    logic             rd_acc;
    logic [NCHAN-1:0] ctl_wr, ctl_rd, dat_wr, dat_rd;
    logic [NCHAN-1:0] reset_me, store_en, cmd_hit;
    logic [IDX_W-1:0] ptr_w     [NCHAN];
    logic [REG_W-1:0] rd_byte_w [NCHAN];
    logic [REG_W-1:0] rx_w      [NCHAN];
    logic [NREG*REG_W-1:0] wflat_w [NCHAN];
    logic [RATE_W-1:0]     rate_w  [NCHAN];
    logic             rst_cmd;
    logic [IDX_W-1:0] ptr_b_w, ptr_a_w;

    sccx_addr_decode #(.ADDR_SHIFT(ADDR_SHIFT)) u_dec (
        .addr     (bus_addr),
        .chan_sel (chan_sel),
        .is_data  (is_data)
    );

    assign rd_acc  = bus_rd && !bus_wr;
    assign rx_w[0] = rx_byte_b;
    assign rx_w[1] = rx_byte_a;

    assign rst_cmd     = bus_wr && !is_data && (ptr_w[chan_sel] == IDX_RESET_CMD);
    assign reset_me[0] = rst_cmd && bus_wdata[6];
    assign reset_me[1] = rst_cmd && bus_wdata[7];

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        logic here;
        assign here      = (chan_sel == 1'(c));
        assign ctl_wr[c] = bus_wr && !is_data && here;
        assign ctl_rd[c] = rd_acc && !is_data && here;
        assign dat_wr[c] = bus_wr && is_data && here;
        assign dat_rd[c] = rd_acc && is_data && here;
        assign store_en[c] = ctl_wr[c] && (ptr_w[c] != '0) && (ptr_w[c] != IDX_RESET_CMD);
        assign cmd_hit[c]  = ctl_wr[c] && (ptr_w[c] == '0) &&
                             (bus_wdata[5:3] != 3'd0) && (bus_wdata[5:3] != CMD_POINT_HIGH);

        sccx_ptr_fsm u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_wr   (ctl_wr[c]),
            .ctl_rd   (ctl_rd[c]),
            .wbyte    (bus_wdata),
            .reset_me (reset_me[c]),
            .ptr      (ptr_w[c])
        );

        sccx_chan_regs u_regs (
            .clk            (clk),
            .rst_n          (rst_n),
            .strap_disabled (strap_disabled),
            .soft_rst       (reset_me[c]),
            .store_en       (store_en[c]),
            .store_idx      (ptr_w[c]),
            .store_byte     (bus_wdata),
            .rd_idx         (ptr_w[c]),
            .rd_byte        (rd_byte_w[c]),
            .wreg_flat      (wflat_w[c]),
            .rate_div       (rate_w[c])
        );
    end

    assign wreg_b     = wflat_w[0];
    assign wreg_a     = wflat_w[1];
    assign rate_div_b = rate_w[0];
    assign rate_div_a = rate_w[1];
    assign ptr_b_w    = ptr_w[0];
    assign ptr_a_w    = ptr_w[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata   <= '0;
            cmd_stb     <= '0;
            cmd_code    <= '0;
            data_wr_stb <= '0;
            data_rd_stb <= '0;
            tx_byte     <= '0;
        end else begin
            cmd_stb     <= cmd_hit;
            data_wr_stb <= dat_wr;
            data_rd_stb <= dat_rd;
            if (|cmd_hit)
                cmd_code <= bus_wdata[5:3];
            if (|dat_wr)
                tx_byte <= bus_wdata;
            if (rd_acc)
                bus_rdata <= is_data ? rx_w[chan_sel] : rd_byte_w[chan_sel];
        end
    end
endmodule

module sccx_regport_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic         bus_rd,
    input logic [7:0]   bus_wdata,
    input logic [1:0]   ctl_wr,
    input logic [1:0]   ctl_rd,
    input logic [1:0]   reset_me,
    input logic [3:0]   ptr_b,
    input logic [3:0]   ptr_a,
    input logic [127:0] wreg_b,
    input logic [127:0] wreg_a,
    input logic [7:0]   bus_rdata,
    input logic [1:0]   cmd_stb,
    input logic [1:0]   data_wr_stb,
    input logic [1:0]   data_rd_stb
);
    assert_read_clears_ptr_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd[0] |=> ptr_b == 4'd0);
    assert_read_clears_ptr_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd[1] |=> ptr_a == 4'd0);
    assert_store_mode_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr[0] && ptr_b == 4'd4) |=> wreg_b[39:32] == $past(bus_wdata));
    assert_soft_reset_values_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_me[1] |=> (wreg_a[39:32] == 8'h04 && wreg_a[127:120] == 8'hF8));
    assert_reset_cmd_not_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr[1] && ptr_a == 4'd9) |=> wreg_a[79:72] == 8'hC0);
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_wr) |=> $stable(bus_rdata));
    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_wr_stb) && $onehot0(data_rd_stb) && $onehot0(cmd_stb));
endmodule

bind sccx_regport sccx_regport_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .ctl_wr      (ctl_wr),
    .ctl_rd      (ctl_rd),
    .reset_me    (reset_me),
    .ptr_b       (ptr_b_w),
    .ptr_a       (ptr_a_w),
    .wreg_b      (wreg_b),
    .wreg_a      (wreg_a),
    .bus_rdata   (bus_rdata),
    .cmd_stb     (cmd_stb),
    .data_wr_stb (data_wr_stb),
    .data_rd_stb (data_rd_stb)
);

// File: tb/sccx_regport_tb_top.sv
module sccx_regport_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strap_disabled = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [7:0]   rx_byte_b = 8'h00, rx_byte_a = 8'h00;
    logic [127:0] wreg_b, wreg_a;
    logic [22:0]  rate_div_b, rate_div_a;
    logic [1:0]   cmd_stb, data_wr_stb, data_rd_stb;
    logic [2:0]   cmd_code;
    logic [7:0]   tx_byte;

    int errors = 0;
    int checks = 0;
    logic [7:0] mw [2][16];
    logic [7:0] mr [2][16];

    always #5 clk = ~clk;

    sccx_regport dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mreset(input int ch);
        for (int i = 0; i < 16; i++) begin
            mw[ch][i] = 8'h00;
            mr[ch][i] = 8'h00;
        end
        mw[ch][4] = 8'h04; mw[ch][9] = 8'hC0; mw[ch][11] = 8'h08;
        mw[ch][14] = 8'h30; mw[ch][15] = 8'hF8;
        mr[ch][0] = strap_disabled ? 8'h7C : 8'h44;
        mr[ch][1] = 8'h07;
    endtask

    task automatic bus_op(input bit w, input bit r, input bit ch, input bit dat, input logic [7:0] b);
        bus_wr = w; bus_rd = r; bus_addr = {ch, dat}; bus_wdata = b;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic set_ptr(input bit ch, input int idx);
        bus_op(1, 0, ch, 0, {2'b00, (idx > 7) ? 3'b001 : 3'b000, 3'(idx)});
    endtask

    task automatic wr_reg(input bit ch, input int idx, input logic [7:0] v);
        set_ptr(ch, idx);
        bus_op(1, 0, ch, 0, v);
        if (idx != 9) mw[ch][idx] = v;
        if (idx == 12 || idx == 13) mr[ch][idx] = v;
    endtask

    task automatic rd_reg(input bit ch, input int idx, output logic [7:0] v);
        set_ptr(ch, idx);
        bus_op(0, 1, ch, 0, 8'h00);
        v = bus_rdata;
    endtask

    task automatic check_wregs(input bit ch, input string req);
        for (int i = 0; i < 16; i++)
            chk(req, ch ? wreg_a[i*8 +: 8] : wreg_b[i*8 +: 8], mw[ch][i]);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [31:0] exp_rate;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mreset(0); mreset(1);

        // R7 reset state
        check_wregs(0, "R7 reset wregs B");
        check_wregs(1, "R7 reset wregs A");
        rd_reg(0, 0, v); chk("R7 rreg0", v, 8'h44);
        rd_reg(1, 1, v); chk("R7 rreg1", v, 8'h07);
        chk("R8 reset rate", rate_div_b, 2);

        // R4, R2 high bank, R1 channel mapping: sweep all registers on both channels
        for (int ch = 0; ch < 2; ch++)
            for (int idx = 1; idx < 16; idx++)
                if (idx != 9) wr_reg(ch[0], idx, 8'((ch * 16 + idx) * 7 + 3));
        check_wregs(0, "R4 R1 sweep B");
        check_wregs(1, "R4 R1 sweep A");

        // R5 mirror, read register map
        for (int ch = 0; ch < 2; ch++) begin
            rd_reg(ch[0], 12, v); chk("R5 mirror 12", v, mr[ch][12]);
            rd_reg(ch[0], 13, v); chk("R5 mirror 13", v, mr[ch][13]);
            rd_reg(ch[0], 5, v);  chk("R5 rreg5 zero", v, 8'h00);
        end

        // R3 pointer returns to zero after write and after read
        wr_reg(1, 13, 8'h9E);
        bus_op(0, 1, 1, 0, 8'h00); chk("R3 ptr zero after write", bus_rdata, 8'h44);
        rd_reg(0, 12, v);
        bus_op(0, 1, 0, 0, 8'h00); chk("R3 ptr zero after read", bus_rdata, 8'h44);

        // R8 rate sweep
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                logic [15:0] d;
                int sh;
                d = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0001 : (k == 2) ? 16'h1234 : 16'hFFFF;
                sh = (m == 0) ? 0 : (m == 1) ? 4 : (m == 2) ? 5 : 6;
                wr_reg(0, 4, {2'(m), 6'h04});
                wr_reg(0, 12, d[7:0]);
                wr_reg(0, 13, d[15:8]);
                exp_rate = (32'(d) + 32'd2) << sh;
                chk("R8 rate", 32'(rate_div_b), exp_rate);
            end
        end

        // R2 command strobe and point-high
        bus_op(1, 0, 1, 0, 8'h28);
        chk("R2 cmd_stb", cmd_stb, 2'b10);
        chk("R2 cmd_code", cmd_code, 3'd5);
        bus_op(1, 0, 1, 0, 8'h08);
        chk("R2 point high no strobe", cmd_stb, 2'b00);
        bus_op(0, 1, 1, 0, 8'h00); chk("R2 high ptr reads rreg8", bus_rdata, 8'h00);
        bus_op(0, 1, 1, 0, 8'h00); chk("R2 ptr back to zero", bus_rdata, 8'h44);

        // R6 single reset from A resets B, A pointer held at 9
        set_ptr(1, 9);
        bus_op(1, 0, 1, 0, 8'h40);
        mreset(0);
        check_wregs(0, "R6 B reset by A");
        check_wregs(1, "R6 A untouched");
        bus_op(0, 1, 1, 0, 8'h00); chk("R6 A ptr held at 9", bus_rdata, 8'h00);
        bus_op(0, 1, 1, 0, 8'h00); chk("R6 A ptr back to 0", bus_rdata, 8'h44);

        // R6 code 00 has no effect
        wr_reg(0, 11, 8'h5C);
        set_ptr(0, 9);
        bus_op(1, 0, 0, 0, 8'h00);
        check_wregs(0, "R6 code 00 no effect");
        bus_op(0, 1, 0, 0, 8'h00); chk("R6 code 00 ptr zero", bus_rdata, 8'h44);

        // R6 B resets A, then held pointer resets both
        wr_reg(0, 5, 8'h11);
        set_ptr(0, 9);
        bus_op(1, 0, 0, 0, 8'h80);
        mreset(1);
        check_wregs(1, "R6 A reset by B");
        chk("R6 B reg5 kept", wreg_b[47:40], 8'h11);
        bus_op(1, 0, 0, 0, 8'hC0);
        mreset(0); mreset(1);
        check_wregs(0, "R6 both reset B");
        check_wregs(1, "R6 both reset A");
        bus_op(0, 1, 0, 0, 8'h00); chk("R6 ptr zero after both", bus_rdata, 8'h44);

        // R9 data port, pointer untouched
        wr_reg(0, 12, 8'h5A);
        set_ptr(0, 12);
        bus_op(1, 0, 0, 1, 8'hA5);
        chk("R9 data_wr_stb", data_wr_stb, 2'b01);
        chk("R9 tx_byte", tx_byte, 8'hA5);
        rx_byte_a = 8'h3C;
        bus_op(0, 1, 1, 1, 8'h00);
        chk("R9 R1 data read A", bus_rdata, 8'h3C);
        chk("R9 data_rd_stb", data_rd_stb, 2'b10);
        bus_op(0, 1, 0, 0, 8'h00); chk("R9 ptr untouched", bus_rdata, 8'h5A);

        // R10 write wins over read
        bus_op(1, 1, 0, 1, 8'h77);
        chk("R10 rdata held", bus_rdata, 8'h5A);
        chk("R10 write done", tx_byte, 8'h77);

        // R7 strap
        strap_disabled = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_reg(0, 0, v); chk("R7 strap rreg0", v, 8'h7C);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule